// File: doc/BRIEF.md
# Program Memory Lock Checker

This block sits in front of an on-chip program store. Each access is judged against a two-bit lock setting. The block answers with a grant, and for a refused read it substitutes a fixed byte for the stored data. A refused read still finishes as a normal read cycle: the requester sees `rd_subst` high and receives all-ones data.

Reads of the protected window are allowed only for code running from internal program space. The block judges this from the prefetch counter value `fetch_ctr`, not from the architectural program counter. Because that counter runs ahead of execution, code in the last few locations of program space counts as external. Writes to the write window are refused whenever write protection is on, whoever makes them.

The lock bits are taken once while the reset sequence runs and then stay frozen until the next reset. A test path can open the read window without internal execution. To do so it must first pass a sequential 16-byte key comparison, in which key bytes fetched from outside are compared with the internal key. One mismatched byte closes that path until reset.

Top module: `prog_lock_guard`

The configuration block has two states:
- `CFG_WAIT`: after reset, the lock bits are still open to a load.
- `CFG_HELD`: the lock bits are frozen. The block enters it from `CFG_WAIT` on a load, or when `boot_seq` is low.

The key comparator has four states:
- `KEY_IDLE`: goes to `KEY_RUN` on `key_start`.
- `KEY_RUN`: goes to `KEY_FAIL` on any unequal strobed pair. It goes to `KEY_PASS` on an equal 16th pair.
- `KEY_PASS`: sticky until reset.
- `KEY_FAIL`: sticky until reset.

## Requirements
- R1: The lock bits are bits 7:6 of the configuration byte, presented on `cfg_lock_bits[1:0]`. Bit 1 (byte bit 7) low enables read protection. Bit 0 (byte bit 6) low enables write protection. So 00 protects both, 01 protects reads only, 10 protects writes only, and 11 protects nothing.
- R2: The read-protected window is 2020h to 3FFFh and the write-protected window is 2000h to 3FFFh. An access outside its window is always granted, including reads of 2000h to 201Fh.
- R3: Outside test mode, a read inside an active read window is granted only when `fetch_ctr` lies in 2000h to 3FFAh inclusive.
- R4: A write inside an active write window is refused regardless of `fetch_ctr`, `test_mode` and the key result.
- R5: A refused read drives `grant` low, `rd_subst` high and `rdata` = FFh. A granted read passes `mem_rdata` to `rdata` unchanged. A write never raises `rd_subst`.
- R6: The lock bits load only on `cfg_wr` while `boot_seq` is high and no load has yet occurred since reset. The new setting governs accesses from the next cycle on. Every later `cfg_wr` is ignored until reset.
- R7: After reset and before any load, the lock setting is 11 (no protection), `key_busy` is 0 and `key_unlocked` is 0.
- R8: `key_start` in the idle state begins a comparison and raises `key_busy`. After 16 `key_strobe` cycles with `key_ext` equal to `key_int`, `key_unlocked` rises in the cycle after the 16th strobe and `key_busy` falls.
- R9: The first unequal strobed pair ends the comparison with `key_unlocked` low and `key_busy` low. Further strobes and `key_start` pulses have no effect until reset.
- R10: In test mode, a read inside an active read window is granted exactly when `key_unlocked` is high, whatever `fetch_ctr` holds.
- R11: With `req_valid` low, `grant` and `rd_subst` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_seq | input | 1 | High while the reset sequence runs |
| cfg_wr | input | 1 | Load strobe for the lock bits |
| cfg_lock_bits | input | 2 | Bits 7:6 of the configuration byte |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| fetch_ctr | input | 16 | Prefetch counter value of the requesting code |
| test_mode | input | 1 | Access comes from the test/programming path |
| mem_rdata | input | 8 | Data read from the program store |
| key_start | input | 1 | Begin a key comparison |
| key_strobe | input | 1 | A key byte pair is present |
| key_ext | input | 8 | Key byte fetched from outside |
| key_int | input | 8 | Internal key byte |
| grant | output | 1 | Access permitted |
| rd_subst | output | 1 | Read refused, data substituted |
| rdata | output | 8 | Read data returned to the requester |
| key_busy | output | 1 | Comparison in progress |
| key_unlocked | output | 1 | Key matched since reset |

## Verification
Two overlaps are provoked. First, a lock-bit load and an access to the write window are driven in the same cycle. The bench expects that access to be judged by the old setting, and the same access one cycle later by the new one. Second, a test-mode read of the read window is issued in the cycle of the 16th matching key strobe. It must be refused, and the identical read one cycle later must be granted. Every other access comes from sweeps over all four lock settings, window-edge addresses, counter values either side of 3FFAh, both directions and both modes, each judged against an arithmetic model.

// File: rtl/pmlock_pkg.sv
package pmlock_pkg;

    typedef enum logic [0:0] {
        CFG_WAIT = 1'b0,
        CFG_HELD = 1'b1
    } cfg_state_t;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_RUN  = 2'd1,
        KEY_PASS = 2'd2,
        KEY_FAIL = 2'd3
    } key_state_t;

    // lock bits: [1] = byte bit 7 (read), [0] = byte bit 6 (write); 0 = protect
    localparam logic [1:0] LOCK_NONE = 2'b11;

endpackage

// File: rtl/pmlock_cfg.sv
module pmlock_cfg
    import pmlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boot_seq,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_lock_bits,
    output logic       read_prot,
    output logic       write_prot
);

    cfg_state_t state_q, state_d;
    logic [1:0] lock_q;
    logic       capture;

    assign capture = (state_q == CFG_WAIT) && boot_seq && cfg_wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_WAIT: if (capture || !boot_seq) state_d = CFG_HELD;
            CFG_HELD: state_d = CFG_HELD;
            default:  state_d = CFG_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_WAIT;
            lock_q  <= LOCK_NONE;
        end else begin
            state_q <= state_d;
            if (capture) lock_q <= cfg_lock_bits;
        end
    end

    always_comb begin
        read_prot  = ~lock_q[1];
        write_prot = ~lock_q[0];
    end

    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_HELD) |=> $stable(lock_q));

    assert_held_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_HELD) |=> (state_q == CFG_HELD));

endmodule

// File: rtl/pmlock_keycmp.sv
module pmlock_keycmp
    import pmlock_pkg::*;
#(
    parameter int KEY_LEN = 16,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_start,
    input  logic              key_strobe,
    input  logic [BYTE_W-1:0] key_ext,
    input  logic [BYTE_W-1:0] key_int,
    output logic              key_busy,
    output logic              key_unlocked
);

    localparam int CNT_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(KEY_LEN - 1);

    key_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             pair_eq;
    logic             at_last;

    assign pair_eq = (key_ext == key_int);
    assign at_last = (cnt_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: if (key_start) state_d = KEY_RUN;
            KEY_RUN: begin
                if (key_strobe) begin
                    if (!pair_eq)     state_d = KEY_FAIL;
                    else if (at_last) state_d = KEY_PASS;
                end
            end
            KEY_PASS: state_d = KEY_PASS;
            KEY_FAIL: state_d = KEY_FAIL;
            default:  state_d = KEY_FAIL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == KEY_IDLE)                 cnt_q <= '0;
            else if (state_q == KEY_RUN && key_strobe) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        key_busy     = (state_q == KEY_RUN);
        key_unlocked = (state_q == KEY_PASS);
    end

    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_FAIL) |=> (state_q == KEY_FAIL));

    assert_unlock_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_unlocked) |-> ($past(key_strobe) && $past(key_busy)));

    assert_busy_unlock_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_busy && key_unlocked));

endmodule

// File: rtl/pmlock_decode.sv
module pmlock_decode #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] WR_LO = 16'h2000,
    parameter logic [ADDR_W-1:0] RD_LO = 16'h2020,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'h3FFF,
    parameter int EXEC_MARGIN = 5
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] fetch_ctr,
    input  logic              test_mode,
    input  logic              key_unlocked,
    input  logic              read_prot,
    input  logic              write_prot,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              grant,
    output logic              rd_subst,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] EXEC_HI = WIN_HI - ADDR_W'(EXEC_MARGIN);

    logic in_rd_win, in_wr_win, internal_code;
    logic rd_ok, wr_ok, allowed;

    always_comb begin
        in_rd_win     = (req_addr >= RD_LO) && (req_addr <= WIN_HI);
        in_wr_win     = (req_addr >= WR_LO) && (req_addr <= WIN_HI);
        internal_code = (fetch_ctr >= WR_LO) && (fetch_ctr <= EXEC_HI);
        wr_ok   = !(write_prot && in_wr_win);
        rd_ok   = !(read_prot && in_rd_win) ||
                  (test_mode ? key_unlocked : internal_code);
        allowed = req_write ? wr_ok : rd_ok;
        grant    = req_valid && allowed;
        rd_subst = req_valid && !req_write && !allowed;
        rdata    = rd_subst ? {DATA_W{1'b1}} : mem_rdata;
    end

endmodule

// File: rtl/prog_lock_guard.sv
module prog_lock_guard
    import pmlock_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int KEY_LEN = 16,
    parameter logic [ADDR_W-1:0] WR_LO = 16'h2000,
    parameter logic [ADDR_W-1:0] RD_LO = 16'h2020,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'h3FFF,
    parameter int EXEC_MARGIN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_seq,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_lock_bits,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] fetch_ctr,
    input  logic              test_mode,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              key_start,
    input  logic              key_strobe,
    input  logic [DATA_W-1:0] key_ext,
    input  logic [DATA_W-1:0] key_int,
    output logic              grant,
    output logic              rd_subst,
    output logic [DATA_W-1:0] rdata,
    output logic              key_busy,
    output logic              key_unlocked
);

    logic read_prot, write_prot;

    pmlock_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .boot_seq(boot_seq), .cfg_wr(cfg_wr),
        .cfg_lock_bits(cfg_lock_bits), .read_prot(read_prot), .write_prot(write_prot)
    );

    pmlock_keycmp #(.KEY_LEN(KEY_LEN), .BYTE_W(DATA_W)) u_key (
        .clk(clk), .rst_n(rst_n), .key_start(key_start), .key_strobe(key_strobe),
        .key_ext(key_ext), .key_int(key_int), .key_busy(key_busy),
        .key_unlocked(key_unlocked)
    );

    pmlock_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_LO(WR_LO), .RD_LO(RD_LO),
        .WIN_HI(WIN_HI), .EXEC_MARGIN(EXEC_MARGIN)
    ) u_dec (
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .fetch_ctr(fetch_ctr), .test_mode(test_mode), .key_unlocked(key_unlocked),
        .read_prot(read_prot), .write_prot(write_prot), .mem_rdata(mem_rdata),
        .grant(grant), .rd_subst(rd_subst), .rdata(rdata)
    );

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grant && !rd_subst));

    assert_write_no_subst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> !rd_subst);

    assert_subst_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_subst |-> (rdata == {DATA_W{1'b1}} && !grant));

    assert_wp_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && write_prot && key_unlocked &&
         req_addr >= WR_LO && req_addr <= WIN_HI) |-> !grant);

endmodule

// File: tb/prog_lock_guard_tb.sv
module prog_lock_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n, boot_seq, cfg_wr;
    logic [1:0]  cfg_lock_bits;
    logic        req_valid, req_write, test_mode;
    logic [15:0] req_addr, fetch_ctr;
    logic [7:0]  mem_rdata, key_ext, key_int, rdata;
    logic        key_start, key_strobe;
    logic        grant, rd_subst, key_busy, key_unlocked;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    prog_lock_guard u_dut (
        .clk(clk), .rst_n(rst_n), .boot_seq(boot_seq), .cfg_wr(cfg_wr),
        .cfg_lock_bits(cfg_lock_bits), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .fetch_ctr(fetch_ctr), .test_mode(test_mode),
        .mem_rdata(mem_rdata), .key_start(key_start), .key_strobe(key_strobe),
        .key_ext(key_ext), .key_int(key_int), .grant(grant), .rd_subst(rd_subst),
        .rdata(rdata), .key_busy(key_busy), .key_unlocked(key_unlocked)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit model_ok(int mode, int a, bit wr, int f, bit tm, bit unl);
        bit rp = (mode & 2) == 0;
        bit wp = (mode & 1) == 0;
        if (wr) return !(wp && a >= 'h2000 && a <= 'h3FFF);
        if (!(rp && a >= 'h2020 && a <= 'h3FFF)) return 1'b1;
        return tm ? unl : (f >= 'h2000 && f <= 'h3FFA);
    endfunction

    // drive one access at a negedge and judge the combinational answer
    task automatic access(input int mode, input logic [15:0] a, input bit wr,
                          input logic [15:0] f, input bit tm, input bit unl,
                          input string req);
        bit ok;
        int exp_word, act_word;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; fetch_ctr = f;
        test_mode = tm; mem_rdata = a[7:0] ^ 8'h3C;
        #1;
        ok = model_ok(mode, a, wr, f, tm, unl);
        exp_word = {ok, (!wr && !ok), ((!wr && !ok) ? 8'hFF : (a[7:0] ^ 8'h3C))};
        act_word = {grant, rd_subst, rdata};
        chk(act_word == exp_word, req, act_word, exp_word);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; boot_seq = 1'b1; cfg_wr = 1'b0; req_valid = 1'b0;
        key_start = 1'b0; key_strobe = 1'b0; test_mode = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_lock_bits = m;
        @(negedge clk);
        cfg_wr = 1'b0; boot_seq = 1'b0;
    endtask

    function automatic logic [7:0] kbyte(int i);
        return 8'(i * 37 + 11);
    endfunction

    logic [15:0] apts [9];
    logic [15:0] fpts [6];

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        apts = '{16'h0000, 16'h1FFF, 16'h2000, 16'h201F, 16'h2020,
                 16'h3000, 16'h3FFF, 16'h4000, 16'hFFFF};
        fpts = '{16'h1FFF, 16'h2000, 16'h3FFA, 16'h3FFB, 16'h3FFF, 16'h8000};
        cfg_lock_bits = 2'b00; key_ext = 8'h00; key_int = 8'h00;
        req_addr = '0; fetch_ctr = '0; mem_rdata = '0; req_write = 1'b0;
        do_reset();

        // R7: reset state, no load yet -> no protection
        #1;
        chk(key_busy == 1'b0 && key_unlocked == 1'b0, "R7 key idle", {key_busy, key_unlocked}, 0);
        access(3, 16'h2000, 1'b1, 16'h0000, 1'b0, 1'b0, "R7 unprotected write");
        access(3, 16'h3000, 1'b0, 16'h9000, 1'b0, 1'b0, "R7 unprotected read");

        // R6: load 11, later loads ignored (during boot and after)
        load_mode(2'b11);
        do_reset();
        @(negedge clk); cfg_wr = 1'b1; cfg_lock_bits = 2'b11;
        @(negedge clk); cfg_lock_bits = 2'b00;
        @(negedge clk); cfg_wr = 1'b0;
        access(3, 16'h3000, 1'b1, 16'h0000, 1'b0, 1'b0, "R6 second load ignored");
        @(negedge clk); boot_seq = 1'b0; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        access(3, 16'h2500, 1'b0, 16'h0000, 1'b0, 1'b0, "R6 load after boot ignored");

        // overlap: load 00 in the same cycle as a write to the window
        do_reset();
        @(negedge clk);
        cfg_wr = 1'b1; cfg_lock_bits = 2'b00;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h2000;
        #1;
        chk(grant == 1'b1, "R6 same-cycle load uses old setting", grant, 1);
        @(negedge clk);
        cfg_wr = 1'b0; boot_seq = 1'b0;
        #1;
        chk(grant == 1'b0, "R6 new setting next cycle", grant, 0);
        req_valid = 1'b0;

        // R1 R2 R3 R4 R5 R10: sweep every lock setting
        for (int m = 0; m < 4; m++) begin
            do_reset();
            load_mode(2'(m));
            for (int ai = 0; ai < 9; ai++)
                for (int fi = 0; fi < 6; fi++)
                    for (int w = 0; w < 2; w++)
                        for (int t = 0; t < 2; t++)
                            access(m, apts[ai], w[0], fpts[fi], t[0], 1'b0,
                                   "R1 R2 R3 R4 R5 R10 sweep");
        end

        // R11: no request
        @(negedge clk); req_valid = 1'b0; req_write = 1'b0; req_addr = 16'h3000;
        #1;
        chk(grant == 1'b0 && rd_subst == 1'b0, "R11 idle outputs", {grant, rd_subst}, 0);

        // R8 R10: matching key under full protection
        do_reset();
        load_mode(2'b00);
        @(negedge clk); key_start = 1'b1;
        @(negedge clk); key_start = 1'b0;
        #1;
        chk(key_busy == 1'b1, "R8 busy after start", key_busy, 1);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            key_strobe = 1'b1; key_ext = kbyte(i); key_int = kbyte(i);
            if (i == 15) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h3000;
                test_mode = 1'b1; fetch_ctr = 16'h9000; mem_rdata = 8'h42;
                #1;
                chk(grant == 1'b0 && rd_subst == 1'b1, "R10 read in last-strobe cycle refused",
                    {grant, rd_subst}, 1);
                chk(key_unlocked == 1'b0, "R8 not yet unlocked", key_unlocked, 0);
            end
        end
        @(negedge clk);
        key_strobe = 1'b0;
        #1;
        chk(key_unlocked == 1'b1 && key_busy == 1'b0, "R8 unlocked after 16th strobe",
            {key_unlocked, key_busy}, 2);
        chk(grant == 1'b1 && rdata == 8'h42, "R10 read granted after unlock",
            {grant, rdata}, {1'b1, 8'h42});
        req_valid = 1'b0;
        access(0, 16'h3FFF, 1'b0, 16'h0000, 1'b1, 1'b1, "R10 unlocked test read");
        access(0, 16'h3FFF, 1'b0, 16'h0000, 1'b0, 1'b1, "R3 unlock does not help normal mode");
        access(0, 16'h2100, 1'b1, 16'h2100, 1'b1, 1'b1, "R4 write refused even unlocked");

        // R9: mismatch at byte 5, then retries ignored
        do_reset();
        boot_seq = 1'b0;
        @(negedge clk); key_start = 1'b1;
        @(negedge clk); key_start = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            key_strobe = 1'b1; key_int = kbyte(i);
            key_ext = (i == 5) ? ~kbyte(i) : kbyte(i);
        end
        @(negedge clk); key_strobe = 1'b0;
        #1;
        chk(key_unlocked == 1'b0 && key_busy == 1'b0, "R9 mismatch fails",
            {key_unlocked, key_busy}, 0);
        @(negedge clk); key_start = 1'b1;
        @(negedge clk); key_start = 1'b0;
        #1;
        chk(key_busy == 1'b0, "R9 restart ignored", key_busy, 0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            key_strobe = 1'b1; key_ext = kbyte(i); key_int = kbyte(i);
        end
        @(negedge clk); key_strobe = 1'b0;
        #1;
        chk(key_unlocked == 1'b0, "R9 stays locked until reset", key_unlocked, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule